// File: doc/BRIEF.md
# Delayed Branch Squash Controller

This block sits beside the execute stage of an eight-stage in-order pipeline. A branch's condition and target are only known at the end of execute, so by then three younger instructions are already in flight. The oldest of them is the architectural delay slot. The other two are either fall-through instructions or bubbles, depending on the static prediction policy. In the cycle the branch resolves, the controller decides which of the three shadow slots to annul. It also decides whether fetch must be redirected, and to which address.

A likely-type branch annuls its delay slot when it falls through. Under predict-taken the two later slots are bubbles and are always marked killed. Under predict-not-taken they are real fall-through instructions, kept on a not-taken outcome and killed on a taken one. After accepting a branch, a small state machine follows the instruction in each shadow slot as it passes through execute. A branch in a slot that was annulled is ignored. A branch in a kept second or third slot is resolved normally. A branch in a live delay slot is unsupported: it is reported on an error output and takes no action.

The machine has four states. SH_IDLE means no shadow is open. SH_SLOT1 means the delay slot is in execute. SH_SLOT2 and SH_SLOT3 mean the second and third shadow instructions are in execute. The transitions are as follows:
- An accepted branch moves the machine from SH_IDLE, SH_SLOT2 or SH_SLOT3 to SH_SLOT1.
- SH_SLOT1 always moves to SH_SLOT2.
- SH_SLOT2 moves to SH_SLOT3 unless a branch is accepted.
- SH_SLOT3 moves to SH_IDLE unless a branch is accepted.
- SH_IDLE holds while no branch arrives.

Reset places the machine in SH_IDLE.

Top module: `branch_shadow_ctrl`

## Requirements
- R1: After reset, with no branch presented, redirect, kill vector and error outputs are all zero, and the next branch presented is accepted.
- R2: An accepted taken branch raises the redirect strobe with the target address and kill vector 3'b110 under either policy, likely or not; the delay slot (bit 0) is never killed on a taken branch.
- R3: Under predict-not-taken (policy input 0), an accepted ordinary branch that is not taken gives no redirect and kill vector 3'b000.
- R4: An accepted likely branch that is not taken sets kill bit 0 (delay slot): 3'b001 under predict-not-taken, 3'b111 under predict-taken.
- R5: Under predict-taken (policy input 1), an accepted branch that is not taken raises the redirect strobe with the fall-through address, and kill bits 2 and 1 are set.
- R6: Kill bit 0 is the delay slot, bit 1 the second and bit 2 the third shadow slot. Redirect, address and kill outputs are valid in the same cycle as the resolving branch, and the redirect address reads zero when no redirect is raised.
- R7: A branch presented in the cycle after an accepted branch, while the delay slot was not annulled, pulses the error output for that cycle with no redirect and a zero kill vector. The shadow still advances to slot two.
- R8: A branch presented in a shadow slot that was annulled is ignored: no redirect, zero kill vector, no error.
- R9: A branch presented in a kept second or third slot, or once the shadow has closed, is accepted and opens a new shadow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ex_br_valid_i | input | 1 | A branch is resolving in execute this cycle |
| ex_br_likely_i | input | 1 | The resolving branch is likely-type |
| ex_br_taken_i | input | 1 | Condition outcome from execute (1 = taken) |
| ex_target_pc_i | input | PC_W | Branch target address |
| ex_fall_pc_i | input | PC_W | Fall-through address past the delay slot |
| policy_taken_i | input | 1 | Static policy: 1 = predict-taken, 0 = predict-not-taken |
| redir_valid_o | output | 1 | Load the fetch PC this cycle |
| redir_pc_o | output | PC_W | New fetch address, zero when no redirect |
| slot_kill_o | output | 3 | Annul mask for the three shadow slots |
| nested_err_o | output | 1 | Unsupported branch in a live delay slot |

## Verification
On every cycle, the assertions check the outcome of each accepted branch against its taken, likely and policy inputs: the redirect address, a delay slot never lost on a taken branch, and the annulled delay slot of a likely fall-through. They also check that a silent error cycle carries no redirect and no kill, that kills appear only beside a branch, and that the delay-slot state always advances to slot two. Only the bench's scenarios can show the shadow's memory at work across cycles. These cover a branch ignored because its slot was annulled, a branch accepted from a kept later slot, a branch after the shadow closes, and reset abandoning an open shadow.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

    // Number of instructions fetched behind a branch before it resolves
    localparam int SHADOW_SLOTS = 3;

    typedef logic [SHADOW_SLOTS-1:0] kill_vec_t;

    // Which shadow instruction currently occupies execute
    typedef enum logic [1:0] {
        SH_IDLE  = 2'd0,
        SH_SLOT1 = 2'd1,
        SH_SLOT2 = 2'd2,
        SH_SLOT3 = 2'd3
    } shadow_state_e;

    // Slot positions inside the kill vector
    localparam int SLOT_DELAY = 0;
    localparam int SLOT_SECOND = 1;
    localparam int SLOT_THIRD = 2;

endpackage

// File: rtl/bsq_resolve.sv
module bsq_resolve
    import bsq_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            likely_i,
    input  logic            taken_i,
    input  logic            policy_taken_i,
    input  logic [PC_W-1:0] target_pc_i,
    input  logic [PC_W-1:0] fall_pc_i,
    output logic            redir_raw_o,
    output logic [PC_W-1:0] redir_pc_raw_o,
    output kill_vec_t       kill_raw_o
);

    logic later_slots_dead;

    always_comb begin
        // Later slots are bubbles under predict-taken and wrong-path on a taken outcome
        later_slots_dead = taken_i || policy_taken_i;

        kill_raw_o = '0;
        kill_raw_o[SLOT_DELAY]  = likely_i && !taken_i;
        kill_raw_o[SLOT_SECOND] = later_slots_dead;
        kill_raw_o[SLOT_THIRD]  = later_slots_dead;

        // Fetch must move when taken, or when fetch was holding for a taken guess
        redir_raw_o    = taken_i || policy_taken_i;
        redir_pc_raw_o = taken_i ? target_pc_i : fall_pc_i;
    end

endmodule

// File: rtl/bsq_shadow_fsm.sv
module bsq_shadow_fsm
    import bsq_pkg::*;
(
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          br_valid_i,
    input  kill_vec_t     new_kill_i,
    output logic          accept_o,
    output logic          nested_err_o,
    output shadow_state_e state_o
);

    shadow_state_e state_q, state_d;
    kill_vec_t     mask_q;

    // State and annul-mask registers
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= SH_IDLE;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept_o) begin
                mask_q <= new_kill_i;
            end
        end
    end

    // Next state and decisions
    always_comb begin
        accept_o     = 1'b0;
        nested_err_o = 1'b0;
        state_d      = state_q;
        unique case (state_q)
            SH_IDLE: begin
                accept_o = br_valid_i;
                state_d  = br_valid_i ? SH_SLOT1 : SH_IDLE;
            end
            SH_SLOT1: begin
                // A live delay slot may not hold a branch; an annulled one is ignored
                nested_err_o = br_valid_i && !mask_q[SLOT_DELAY];
                state_d      = SH_SLOT2;
            end
            SH_SLOT2: begin
                accept_o = br_valid_i && !mask_q[SLOT_SECOND];
                state_d  = accept_o ? SH_SLOT1 : SH_SLOT3;
            end
            SH_SLOT3: begin
                accept_o = br_valid_i && !mask_q[SLOT_THIRD];
                state_d  = accept_o ? SH_SLOT1 : SH_IDLE;
            end
        endcase
    end

    assign state_o = state_q;

    // R7: the delay slot always hands over to slot two
    assert_delay_slot_advances_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SH_SLOT1) |=> (state_q == SH_SLOT2));

    // R9: every accepted branch opens a shadow at the delay slot
    assert_accept_opens_shadow_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |=> (state_q == SH_SLOT1));

    // R8: nothing is accepted while the delay slot is in execute
    assert_no_accept_in_delay_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == SH_SLOT1) |-> !accept_o);

endmodule

// File: rtl/branch_shadow_ctrl.sv
module branch_shadow_ctrl
    import bsq_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            ex_br_valid_i,
    input  logic            ex_br_likely_i,
    input  logic            ex_br_taken_i,
    input  logic [PC_W-1:0] ex_target_pc_i,
    input  logic [PC_W-1:0] ex_fall_pc_i,
    input  logic            policy_taken_i,
    output logic            redir_valid_o,
    output logic [PC_W-1:0] redir_pc_o,
    output logic [2:0]      slot_kill_o,
    output logic            nested_err_o
);

    logic            redir_raw;
    logic [PC_W-1:0] redir_pc_raw;
    kill_vec_t       kill_raw;
    logic            accept;
    logic            nested_err;
    shadow_state_e   state;

    bsq_resolve #(.PC_W(PC_W)) resolve_i (
        .likely_i       (ex_br_likely_i),
        .taken_i        (ex_br_taken_i),
        .policy_taken_i (policy_taken_i),
        .target_pc_i    (ex_target_pc_i),
        .fall_pc_i      (ex_fall_pc_i),
        .redir_raw_o    (redir_raw),
        .redir_pc_raw_o (redir_pc_raw),
        .kill_raw_o     (kill_raw)
    );

    bsq_shadow_fsm fsm_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .br_valid_i   (ex_br_valid_i),
        .new_kill_i   (kill_raw),
        .accept_o     (accept),
        .nested_err_o (nested_err),
        .state_o      (state)
    );

    // Only an accepted branch may act on fetch or on the shadow
    always_comb begin
        redir_valid_o = accept && redir_raw;
        redir_pc_o    = (accept && redir_raw) ? redir_pc_raw : '0;
        slot_kill_o   = accept ? kill_raw : '0;
        nested_err_o  = nested_err;
    end

    // R2: taken goes to the target and keeps the delay slot
    assert_taken_to_target_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && ex_br_taken_i) |->
            (redir_valid_o && redir_pc_o == ex_target_pc_i
             && !slot_kill_o[SLOT_DELAY] && slot_kill_o[SLOT_THIRD:SLOT_SECOND] == 2'b11));

    // R3: a correct not-taken guess leaves fetch alone
    assert_nt_policy_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && !ex_br_taken_i && !policy_taken_i) |->
            (!redir_valid_o && slot_kill_o[SLOT_THIRD:SLOT_SECOND] == 2'b00));

    // R4: likely fall-through annuls the delay slot
    assert_likely_annuls_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && ex_br_likely_i && !ex_br_taken_i) |-> slot_kill_o[SLOT_DELAY]);

    // R5: wrong taken guess returns fetch to the fall-through path
    assert_pt_fallthrough_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (accept && !ex_br_taken_i && policy_taken_i) |->
            (redir_valid_o && redir_pc_o == ex_fall_pc_i));

    // R6: kills only appear beside a resolving branch
    assert_kill_needs_branch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_kill_o != 3'b000) |-> ex_br_valid_i);

    // R7: an error cycle takes no action
    assert_error_is_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nested_err_o |-> (!redir_valid_o && slot_kill_o == 3'b000));

    // R7: errors only arise with the delay slot in execute
    assert_error_in_delay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        nested_err_o |-> (state == SH_SLOT1 && ex_br_valid_i));

endmodule

// File: tb/branch_shadow_ctrl_tb_top.sv
module branch_shadow_ctrl_tb_top;

    localparam int PC_W = 32;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            br_valid, br_likely, br_taken, pol;
    logic [PC_W-1:0] tgt, fall;
    logic            redir;
    logic [PC_W-1:0] redir_pc;
    logic [2:0]      kill;
    logic            err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    branch_shadow_ctrl #(.PC_W(PC_W)) dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .ex_br_valid_i  (br_valid),
        .ex_br_likely_i (br_likely),
        .ex_br_taken_i  (br_taken),
        .ex_target_pc_i (tgt),
        .ex_fall_pc_i   (fall),
        .policy_taken_i (pol),
        .redir_valid_o  (redir),
        .redir_pc_o     (redir_pc),
        .slot_kill_o    (kill),
        .nested_err_o   (err)
    );

    // {policy, likely, taken, exp_redirect, exp_use_target, exp_kill[2:0]}
    localparam logic [7:0] VEC [8] = '{
        8'b000_00_000,
        8'b001_11_110,
        8'b010_00_001,
        8'b011_11_110,
        8'b100_10_110,
        8'b101_11_110,
        8'b110_10_111,
        8'b111_11_110
    };

    task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Check all outputs at once for one cycle
    task automatic chk_all(input string req, input logic e_redir, input logic [PC_W-1:0] e_pc,
                           input logic [2:0] e_kill, input logic e_err);
        chk({req, " redirect"}, {31'd0, redir}, {31'd0, e_redir});
        chk({req, " pc"}, redir_pc, e_pc);
        chk({req, " kill"}, {29'd0, kill}, {29'd0, e_kill});
        chk({req, " error"}, {31'd0, err}, {31'd0, e_err});
    endtask

    // Present a branch from a falling edge; outputs settle before the next rising edge
    task automatic present(input logic l, input logic t, input logic p, input int seed);
        @(negedge clk);
        br_valid  = 1'b1;
        br_likely = l;
        br_taken  = t;
        pol       = p;
        tgt       = 32'h1000_0040 + seed;
        fall      = 32'h0000_2008 + seed;
        #1;
    endtask

    task automatic quiet(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            br_valid = 1'b0; br_likely = 1'b0; br_taken = 1'b0;
            #1;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        br_valid = 0; br_likely = 0; br_taken = 0; pol = 0; tgt = '0; fall = '0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #1;

        // R1: reset state
        chk_all("R1 reset", 1'b0, '0, 3'b000, 1'b0);

        // Table walk: each policy/likely/taken combination, shadow closed between
        for (int i = 0; i < 8; i++) begin
            logic [7:0] v;
            logic [PC_W-1:0] e_pc;
            v = VEC[i];
            present(v[6], v[5], v[7], i);
            e_pc = v[4] ? (v[3] ? tgt : fall) : '0;
            // R2 R3 R4 R5 R6: outcome in the resolving cycle
            chk_all($sformatf("R2/R3/R4/R5/R6 vec%0d", i), v[4], e_pc, v[2:0], 1'b0);
            quiet(4);
        end

        // R7: branch in a live delay slot
        present(1'b0, 1'b1, 1'b0, 20);
        chk_all("R2 before nest", 1'b1, tgt, 3'b110, 1'b0);
        present(1'b0, 1'b1, 1'b0, 21);
        chk_all("R7 nested", 1'b0, '0, 3'b000, 1'b1);
        // slot two was killed by the taken branch: ignored
        present(1'b0, 1'b1, 1'b0, 22);
        chk_all("R8 after nest slot2", 1'b0, '0, 3'b000, 1'b0);
        quiet(4);

        // R8: annulled delay slot; R9: kept slot two accepted
        present(1'b1, 1'b0, 1'b0, 30);
        chk_all("R4 likely nt", 1'b0, '0, 3'b001, 1'b0);
        present(1'b0, 1'b1, 1'b0, 31);
        chk_all("R8 annulled delay", 1'b0, '0, 3'b000, 1'b0);
        present(1'b0, 1'b1, 1'b0, 32);
        chk_all("R9 kept slot2", 1'b1, tgt, 3'b110, 1'b0);
        quiet(4);

        // R9: kept slot three accepted
        present(1'b0, 1'b0, 1'b0, 40);
        quiet(2);
        present(1'b0, 1'b0, 1'b1, 41);
        chk_all("R9 kept slot3", 1'b1, fall, 3'b110, 1'b0);
        quiet(4);

        // R8: slots two and three killed; R9: accepted once shadow closes
        present(1'b0, 1'b1, 1'b0, 50);
        quiet(1);
        present(1'b0, 1'b1, 1'b0, 51);
        chk_all("R8 killed slot2", 1'b0, '0, 3'b000, 1'b0);
        present(1'b0, 1'b1, 1'b0, 52);
        chk_all("R8 killed slot3", 1'b0, '0, 3'b000, 1'b0);
        present(1'b0, 1'b1, 1'b0, 53);
        chk_all("R9 after close", 1'b1, tgt, 3'b110, 1'b0);
        quiet(4);

        // R1: reset abandons an open shadow
        present(1'b0, 1'b1, 1'b0, 60);
        @(negedge clk); br_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; #1;
        chk_all("R1 reset mid-shadow", 1'b0, '0, 3'b000, 1'b0);
        present(1'b0, 1'b1, 1'b0, 61);
        chk_all("R1 accepted after reset", 1'b1, tgt, 3'b110, 1'b0);
        quiet(2);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule